// File: doc/BRIEF.md
# Programmable-Flag Clocked FIFO Buffer

This block is a 256-word by 9-bit first-in first-out buffer with a write side and a read side, each on its own clock. The two clocks may come from one source, or they may be unrelated. A word goes in only when both write enables are high together. A word comes out only when both read enables are high together. The outgoing word is held in a register clocked by the read clock.

Four status flags are driven. Empty and almost-empty belong to the read clock. Full and almost-full belong to the write clock. The two almost thresholds are offsets kept in a small register pair. After reset each offset is 7. Both offsets can be rewritten through the write port by raising a load strobe. Pointers cross between the clock domains as Gray code through two-stage synchronizers, so a flag can clear a few cycles of the observing clock after the event that clears it.

An output-enable input sets whether the read bus drives. When it is low, the bus reads as zero and a drive-enable output goes low, so a pad ring can float the pins.

Top module: `pflag_fifo`

## Requirements
- R1: While rst_n is low and after it rises, empty_o and almost_empty_o are 1, full_o and almost_full_o are 0, and rd_data_o is 0 when out_en_i is 1.
- R2: A word is stored at a rising wr_clk edge only when wr_en0_i and wr_en1_i are both 1 and ofs_load_i is 0. A single write enable stores nothing.
- R3: A word is removed at a rising rd_clk edge only when rd_en0_i and rd_en1_i are both 1. It then appears on rd_data_o after that same edge, oldest first. A single read enable leaves rd_data_o and the fill level unchanged.
- R4: A write attempted while full_o is 1 is discarded. The 256 stored words are unchanged.
- R5: A read attempted while empty_o is 1 is discarded. rd_data_o keeps its last value and no word is lost.
- R6: Once settled, full_o is 1 exactly when 256 words are held, and empty_o is 1 exactly when none are held.
- R7: Once settled, almost_empty_o is 1 when the level is at or below the empty offset (7 by default). almost_full_o is 1 when the level is at or above 256 minus the full offset (7 by default). A full buffer is always almost full, and an empty buffer is always almost empty.
- R8: With ofs_load_i and both write enables high, wr_data_i[7:0] is taken as an offset and no word is stored. The first load cycle after reset sets the empty offset, the next sets the full offset, and later load cycles keep alternating. Reset restores both offsets to 7.
- R9: With out_en_i at 0, rd_data_o is 0 and rd_data_oe_o is 0. Reads still take effect, and raising out_en_i shows the registered word.
- R10: With the read clock equal to, slower than, or faster than the write clock, every accepted word is read back once and in order. Each pointer advances by at most one per clock of its domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset of both sides |
| wr_data_i | input | 9 | Word to store, or offset value in bits 7:0 during a load |
| wr_en0_i | input | 1 | First write enable |
| wr_en1_i | input | 1 | Second write enable |
| ofs_load_i | input | 1 | Turns a qualified write cycle into an offset load |
| rd_en0_i | input | 1 | First read enable |
| rd_en1_i | input | 1 | Second read enable |
| out_en_i | input | 1 | Read bus drive enable |
| rd_data_o | output | 9 | Registered read word, zero when not driven |
| rd_data_oe_o | output | 1 | High when the read bus should drive the pins |
| empty_o | output | 1 | No words held (read clock) |
| almost_empty_o | output | 1 | Level at or below the empty offset (read clock) |
| almost_full_o | output | 1 | Level at or above depth minus the full offset (write clock) |
| full_o | output | 1 | 256 words held (write clock) |

## Verification
Some properties are checked on every clock cycle:
- while full, the write address never moves;
- while empty, neither the read address nor the read register moves;
- with fewer than both enables, or during an offset load, nothing moves;
- each address steps by at most one;
- full implies almost full, and empty implies almost empty;
- a disabled bus is quiet.

Other behaviour only the directed scenarios can show:
- where each threshold lies, by settling at the levels on either side of it;
- that a load writes the two offsets in turn and that reset restores them;
- that word order survives equal, slower and faster read clocks;
- that overflow and underflow attempts leave the stored contents intact.

// File: rtl/pflag_fifo_pkg.sv
package pflag_fifo_pkg;
    localparam int DATA_W      = 9;
    localparam int ADDR_W      = 8;
    localparam int DEPTH       = 1 << ADDR_W;
    localparam int PTR_W       = ADDR_W + 1;
    localparam int OFS_DEFAULT = 7;

    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] ofs_t;

    typedef struct packed {
        ptr_t bin;
        ptr_t gray;
        ofs_t ae_ofs;
        ofs_t af_ofs;
        logic ofs_sel;
        logic full;
        logic afull;
    } wr_state_t;

    typedef struct packed {
        ptr_t bin;
        ptr_t gray;
        logic empty;
        logic aempty;
    } rd_state_t;

    function automatic ptr_t to_gray(ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_t from_gray(ptr_t g);
        ptr_t b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/pflag_fifo_sync.sv
module pflag_fifo_sync #(
    parameter int W = pflag_fifo_pkg::PTR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;
endmodule

// File: rtl/pflag_fifo_ram.sv
module pflag_fifo_ram #(
    parameter int AW = pflag_fifo_pkg::ADDR_W,
    parameter int DW = pflag_fifo_pkg::DATA_W
) (
    input  logic          wr_clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          re_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] store [WORDS];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge wr_clk) begin
        if (we_i) begin
            store[waddr_i] <= wdata_i;
        end
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (re_i) begin
            rdata_q <= store[raddr_i];
        end
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/pflag_fifo_wr.sv
module pflag_fifo_wr
    import pflag_fifo_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en0_i,
    input  logic  en1_i,
    input  logic  load_i,
    input  ofs_t  ofs_data_i,
    input  ptr_t  rd_gray_i,
    output logic  push_o,
    output addr_t addr_o,
    output ptr_t  gray_o,
    output ofs_t  ae_ofs_o,
    output logic  full_o,
    output logic  afull_o
);
    wr_state_t s_d;
    wr_state_t s_q;
    logic      both_en;
    logic      do_load;
    logic      do_push;
    ptr_t      rd_bin;
    ptr_t      level;
    ptr_t      af_mark;

    always_comb begin
        s_d     = s_q;
        both_en = en0_i & en1_i;
        do_load = both_en & load_i;
        do_push = both_en & ~load_i & ~s_q.full;

        if (do_load) begin
            if (!s_q.ofs_sel) begin
                s_d.ae_ofs = ofs_data_i;
            end else begin
                s_d.af_ofs = ofs_data_i;
            end
            s_d.ofs_sel = ~s_q.ofs_sel;
        end

        s_d.bin   = s_q.bin + ptr_t'(do_push);
        s_d.gray  = to_gray(s_d.bin);
        rd_bin    = from_gray(rd_gray_i);
        level     = s_d.bin - rd_bin;
        af_mark   = ptr_t'(DEPTH) - ptr_t'(s_d.af_ofs);
        s_d.full  = (level == ptr_t'(DEPTH));
        s_d.afull = (level >= af_mark);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{bin: '0, gray: '0,
                     ae_ofs: ofs_t'(OFS_DEFAULT), af_ofs: ofs_t'(OFS_DEFAULT),
                     ofs_sel: 1'b0, full: 1'b0, afull: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign push_o   = do_push;
    assign addr_o   = s_q.bin[ADDR_W-1:0];
    assign gray_o   = s_q.gray;
    assign ae_ofs_o = s_q.ae_ofs;
    assign full_o   = s_q.full;
    assign afull_o  = s_q.afull;
endmodule

// File: rtl/pflag_fifo_rd.sv
module pflag_fifo_rd
    import pflag_fifo_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en0_i,
    input  logic  en1_i,
    input  ptr_t  wr_gray_i,
    input  ofs_t  ae_ofs_i,
    output logic  pop_o,
    output addr_t addr_o,
    output ptr_t  gray_o,
    output logic  empty_o,
    output logic  aempty_o
);
    rd_state_t s_d;
    rd_state_t s_q;
    logic      do_pop;
    ptr_t      wr_bin;
    ptr_t      level;

    always_comb begin
        s_d        = s_q;
        do_pop     = en0_i & en1_i & ~s_q.empty;
        s_d.bin    = s_q.bin + ptr_t'(do_pop);
        s_d.gray   = to_gray(s_d.bin);
        wr_bin     = from_gray(wr_gray_i);
        level      = wr_bin - s_d.bin;
        s_d.empty  = (level == '0);
        s_d.aempty = (level <= ptr_t'(ae_ofs_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{bin: '0, gray: '0, empty: 1'b1, aempty: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign pop_o    = do_pop;
    assign addr_o   = s_q.bin[ADDR_W-1:0];
    assign gray_o   = s_q.gray;
    assign empty_o  = s_q.empty;
    assign aempty_o = s_q.aempty;
endmodule

// File: rtl/pflag_fifo.sv
module pflag_fifo
    import pflag_fifo_pkg::*;
(
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              wr_en0_i,
    input  logic              wr_en1_i,
    input  logic              ofs_load_i,
    input  logic              rd_en0_i,
    input  logic              rd_en1_i,
    input  logic              out_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_data_oe_o,
    output logic              empty_o,
    output logic              almost_empty_o,
    output logic              almost_full_o,
    output logic              full_o
);
    ptr_t  wr_gray;
    ptr_t  rd_gray;
    ptr_t  wr_gray_rs;
    ptr_t  rd_gray_ws;
    addr_t wr_addr;
    addr_t rd_addr;
    logic  push;
    logic  pop;
    ofs_t  ae_ofs;
    word_t rd_word;

    pflag_fifo_wr u_wr (
        .clk        (wr_clk),
        .rst_n      (rst_n),
        .en0_i      (wr_en0_i),
        .en1_i      (wr_en1_i),
        .load_i     (ofs_load_i),
        .ofs_data_i (wr_data_i[ADDR_W-1:0]),
        .rd_gray_i  (rd_gray_ws),
        .push_o     (push),
        .addr_o     (wr_addr),
        .gray_o     (wr_gray),
        .ae_ofs_o   (ae_ofs),
        .full_o     (full_o),
        .afull_o    (almost_full_o)
    );

    pflag_fifo_sync #(.W(PTR_W)) u_w2r (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .d_i   (wr_gray),
        .q_o   (wr_gray_rs)
    );

    pflag_fifo_sync #(.W(PTR_W)) u_r2w (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .d_i   (rd_gray),
        .q_o   (rd_gray_ws)
    );

    pflag_fifo_rd u_rd (
        .clk       (rd_clk),
        .rst_n     (rst_n),
        .en0_i     (rd_en0_i),
        .en1_i     (rd_en1_i),
        .wr_gray_i (wr_gray_rs),
        .ae_ofs_i  (ae_ofs),
        .pop_o     (pop),
        .addr_o    (rd_addr),
        .gray_o    (rd_gray),
        .empty_o   (empty_o),
        .aempty_o  (almost_empty_o)
    );

    pflag_fifo_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
        .wr_clk  (wr_clk),
        .we_i    (push),
        .waddr_i (wr_addr),
        .wdata_i (wr_data_i),
        .rd_clk  (rd_clk),
        .rst_n   (rst_n),
        .re_i    (pop),
        .raddr_i (rd_addr),
        .rdata_o (rd_word)
    );

    assign rd_data_o    = out_en_i ? rd_word : '0;
    assign rd_data_oe_o = out_en_i;
endmodule

// File: rtl/pflag_fifo_chk.sv
module pflag_fifo_chk
    import pflag_fifo_pkg::*;
(
    input logic  wr_clk,
    input logic  rd_clk,
    input logic  rst_n,
    input logic  wr_en0_i,
    input logic  wr_en1_i,
    input logic  ofs_load_i,
    input logic  rd_en0_i,
    input logic  rd_en1_i,
    input logic  out_en_i,
    input word_t rd_data_o,
    input logic  rd_data_oe_o,
    input logic  empty_o,
    input logic  almost_empty_o,
    input logic  almost_full_o,
    input logic  full_o,
    input addr_t wr_addr,
    input addr_t rd_addr,
    input word_t rd_word
);
    assert_no_overflow_R4: assert property (@(posedge wr_clk) disable iff (!rst_n)
        full_o |=> $stable(wr_addr));

    assert_no_underflow_R5: assert property (@(posedge rd_clk) disable iff (!rst_n)
        empty_o |=> ($stable(rd_addr) && $stable(rd_word)));

    assert_wr_needs_both_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !(wr_en0_i && wr_en1_i) |=> $stable(wr_addr));

    assert_load_stores_nothing_R8: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_en0_i && wr_en1_i && ofs_load_i) |=> $stable(wr_addr));

    assert_rd_needs_both_R3: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !(rd_en0_i && rd_en1_i) |=> ($stable(rd_addr) && $stable(rd_word)));

    assert_wr_step_R10: assert property (@(posedge wr_clk) disable iff (!rst_n)
        1'b1 |=> (wr_addr == $past(wr_addr) || wr_addr == addr_t'($past(wr_addr) + 1'b1)));

    assert_rd_step_R10: assert property (@(posedge rd_clk) disable iff (!rst_n)
        1'b1 |=> (rd_addr == $past(rd_addr) || rd_addr == addr_t'($past(rd_addr) + 1'b1)));

    assert_full_nests_R7: assert property (@(posedge wr_clk) disable iff (!rst_n)
        full_o |-> almost_full_o);

    assert_empty_nests_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
        empty_o |-> almost_empty_o);

    always_comb begin
        if (!out_en_i) begin
            assert_bus_float_R9: assert (rd_data_o == '0 && !rd_data_oe_o);
        end
    end
endmodule

bind pflag_fifo pflag_fifo_chk u_chk (
    .wr_clk         (wr_clk),
    .rd_clk         (rd_clk),
    .rst_n          (rst_n),
    .wr_en0_i       (wr_en0_i),
    .wr_en1_i       (wr_en1_i),
    .ofs_load_i     (ofs_load_i),
    .rd_en0_i       (rd_en0_i),
    .rd_en1_i       (rd_en1_i),
    .out_en_i       (out_en_i),
    .rd_data_o      (rd_data_o),
    .rd_data_oe_o   (rd_data_oe_o),
    .empty_o        (empty_o),
    .almost_empty_o (almost_empty_o),
    .almost_full_o  (almost_full_o),
    .full_o         (full_o),
    .wr_addr        (wr_addr),
    .rd_addr        (rd_addr),
    .rd_word        (rd_word)
);

// File: tb/tb_pflag_fifo.sv
module tb_pflag_fifo;
    logic       wr_clk = 1'b0;
    logic       rd_clk = 1'b0;
    int         rd_half = 5;
    logic       rst_n = 1'b0;
    logic [8:0] wr_data = '0;
    logic       wen0 = 1'b0;
    logic       wen1 = 1'b0;
    logic       ofs_load = 1'b0;
    logic       ren0 = 1'b0;
    logic       ren1 = 1'b0;
    logic       out_en = 1'b1;
    logic [8:0] rd_data;
    logic       rd_oe;
    logic       empty;
    logic       aempty;
    logic       afull;
    logic       full;

    int         checks = 0;
    int         failures = 0;
    logic [8:0] model [$];

    pflag_fifo dut (
        .wr_clk         (wr_clk),
        .rd_clk         (rd_clk),
        .rst_n          (rst_n),
        .wr_data_i      (wr_data),
        .wr_en0_i       (wen0),
        .wr_en1_i       (wen1),
        .ofs_load_i     (ofs_load),
        .rd_en0_i       (ren0),
        .rd_en1_i       (ren1),
        .out_en_i       (out_en),
        .rd_data_o      (rd_data),
        .rd_data_oe_o   (rd_oe),
        .empty_o        (empty),
        .almost_empty_o (aempty),
        .almost_full_o  (afull),
        .full_o         (full)
    );

    initial forever #5 wr_clk = ~wr_clk;
    initial forever #(rd_half) rd_clk = ~rd_clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(posedge wr_clk);
        repeat (8) @(posedge rd_clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wen0 = 0; wen1 = 0; ren0 = 0; ren1 = 0; ofs_load = 0;
        repeat (3) @(posedge wr_clk);
        @(negedge wr_clk);
        rst_n = 1'b1;
        model.delete();
        settle();
    endtask

    task automatic push(input logic [8:0] w);
        logic was_full;
        was_full = full;
        wr_data = w; wen0 = 1; wen1 = 1;
        @(posedge wr_clk);
        #1;
        wen0 = 0; wen1 = 0;
        if (!was_full) model.push_back(w);
    endtask

    task automatic pop_chk(input string tag);
        logic       was_empty;
        logic [8:0] exp;
        was_empty = empty;
        ren0 = 1; ren1 = 1;
        @(posedge rd_clk);
        #1;
        ren0 = 0; ren1 = 0;
        check(!was_empty && model.size() > 0, {tag, " not empty before read"}, was_empty, 0);
        if (!was_empty && model.size() > 0) begin
            exp = model.pop_front();
            check(rd_data == exp, {tag, " read word"}, rd_data, exp);
        end
    endtask

    task automatic t_reset_state();
        check(empty == 1'b1, "R1 empty after reset", empty, 1);
        check(aempty == 1'b1, "R1 almost_empty after reset", aempty, 1);
        check(full == 1'b0, "R1 full after reset", full, 0);
        check(afull == 1'b0, "R1 almost_full after reset", afull, 0);
        check(rd_data == 9'd0, "R1 read data after reset", rd_data, 0);
    endtask

    task automatic t_enable_gating();
        logic [8:0] hold;
        wr_data = 9'h0A5; wen0 = 1; wen1 = 0;
        @(posedge wr_clk); #1;
        wen0 = 0; wen1 = 1;
        @(posedge wr_clk); #1;
        wen1 = 0;
        settle();
        check(empty == 1'b1, "R2 single write enable stores nothing", empty, 1);
        push(9'h13C);
        settle();
        check(empty == 1'b0, "R2 both write enables store", empty, 0);
        hold = rd_data;
        ren0 = 1; ren1 = 0;
        @(posedge rd_clk); #1;
        ren0 = 0; ren1 = 1;
        @(posedge rd_clk); #1;
        ren1 = 0;
        settle();
        check(rd_data == hold, "R3 single read enable keeps data", rd_data, hold);
        check(empty == 1'b0, "R3 single read enable keeps level", empty, 0);
        pop_chk("R3");
        settle();
        check(empty == 1'b1, "R6 empty after last read", empty, 1);
    endtask

    task automatic t_fill_drain();
        logic [8:0] hold;
        for (int lvl = 1; lvl <= 256; lvl++) begin
            push(9'((lvl * 37 + 11) % 512));
            if (lvl == 7 || lvl == 8 || lvl == 248 || lvl == 249 || lvl == 255 || lvl == 256) begin
                settle();
                if (lvl == 7) check(aempty == 1'b1, "R7 almost_empty at level 7", aempty, 1);
                if (lvl == 8) check(aempty == 1'b0, "R7 almost_empty clear at level 8", aempty, 0);
                if (lvl == 248) check(afull == 1'b0, "R7 almost_full clear at level 248", afull, 0);
                if (lvl == 249) check(afull == 1'b1, "R7 almost_full at level 249", afull, 1);
                if (lvl == 255) check(full == 1'b0, "R6 not full at level 255", full, 0);
                if (lvl == 256) check(full == 1'b1, "R6 full at level 256", full, 1);
            end
        end
        push(9'h1AA);
        settle();
        check(full == 1'b1, "R4 still full after extra write", full, 1);
        check(model.size() == 256, "R4 model holds 256", model.size(), 256);
        for (int i = 0; i < 256; i++) pop_chk("R4");
        settle();
        check(empty == 1'b1, "R6 empty after drain", empty, 1);
        check(aempty == 1'b1, "R7 almost_empty when empty", aempty, 1);
        check(full == 1'b0, "R6 full clear after drain", full, 0);
        hold = rd_data;
        ren0 = 1; ren1 = 1;
        @(posedge rd_clk); #1;
        ren0 = 0; ren1 = 0;
        check(rd_data == hold, "R5 read while empty keeps data", rd_data, hold);
        push(9'h0F0);
        settle();
        pop_chk("R5");
    endtask

    task automatic t_offset_load();
        ofs_load = 1; wen0 = 1; wen1 = 1;
        wr_data = 9'd3;
        @(posedge wr_clk); #1;
        wr_data = 9'd20;
        @(posedge wr_clk); #1;
        ofs_load = 0; wen0 = 0; wen1 = 0;
        settle();
        check(empty == 1'b1, "R8 load stores no word", empty, 1);
        for (int i = 0; i < 3; i++) push(9'(i + 100));
        settle();
        check(aempty == 1'b1, "R8 almost_empty at custom level 3", aempty, 1);
        push(9'd200);
        settle();
        check(aempty == 1'b0, "R8 almost_empty clear at level 4", aempty, 0);
        for (int i = 4; i < 235; i++) push(9'(i));
        settle();
        check(afull == 1'b0, "R8 almost_full clear at level 235", afull, 0);
        push(9'd77);
        settle();
        check(afull == 1'b1, "R8 almost_full at custom level 236", afull, 1);
        do_reset();
        for (int i = 0; i < 7; i++) push(9'(i + 300));
        settle();
        check(aempty == 1'b1, "R8 reset restores empty offset 7", aempty, 1);
        push(9'd50);
        settle();
        check(aempty == 1'b0, "R8 level 8 above restored offset", aempty, 0);
        do_reset();
    endtask

    task automatic t_output_enable();
        push(9'h155);
        push(9'h0AB);
        settle();
        out_en = 0;
        #1;
        check(rd_data == 9'd0, "R9 bus zero when disabled", rd_data, 0);
        check(rd_oe == 1'b0, "R9 drive enable low", rd_oe, 0);
        ren0 = 1; ren1 = 1;
        @(posedge rd_clk); #1;
        ren0 = 0; ren1 = 0;
        check(rd_data == 9'd0, "R9 bus stays zero during read", rd_data, 0);
        void'(model.pop_front());
        out_en = 1;
        #1;
        check(rd_data == 9'h155, "R9 word shown after enable", rd_data, 9'h155);
        check(rd_oe == 1'b1, "R9 drive enable high", rd_oe, 1);
        pop_chk("R9");
    endtask

    task automatic t_stream(input int half, input int n);
        rd_half = half;
        do_reset();
        fork
            begin
                for (int i = 0; i < n; i++) begin
                    while (full) begin
                        @(posedge wr_clk); #1;
                    end
                    push(9'((i * 53 + half) % 512));
                end
            end
            begin
                int got;
                got = 0;
                while (got < n) begin
                    if (empty) begin
                        @(posedge rd_clk); #1;
                    end else begin
                        pop_chk("R10");
                        got++;
                    end
                end
            end
        join
        settle();
        check(empty == 1'b1, "R10 empty after stream", empty, 1);
        check(model.size() == 0, "R10 all words consumed", model.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge wr_clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        t_reset_state();
        t_enable_gating();
        t_fill_drain();
        t_offset_load();
        t_output_enable();
        t_stream(5, 300);
        t_stream(7, 400);
        t_stream(3, 400);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule